// File: doc/BRIEF.md
# Parallel Poll Response Unit

This block forms one device's answer during a parallel poll on an IEEE 488 bus. The host loads a response configuration byte holding a disable bit, a sense bit and a 3-bit line number. It also sets or clears a local poll flag, and it writes a source-select bit. That bit decides whether the individual status (ist) comes from the poll flag or from the device's service-request state.

While the bus identifies a poll, the unit drives exactly one data line. A poll is identified when ATN and EOI are both true, given here as active-high inputs. The line is driven only when a response is enabled and ist equals the sense bit. The drive vector and a poll-active flag are registered. Both follow the bus inputs one clock later and drop one clock after the poll ends.

Top module: `ppoll_resp`

## Requirements
- R1: After reset the configuration holds disable = 1, the poll flag is 0 and the source select is 0, so `dio_drive_o` is 0 even during a poll.
- R2: A configuration write with `cfg_data_i[7:5]` = 3'b011 loads the disable bit from bit 4, the sense bit from bit 3 and the line number from bits 2:0. A write with any other value in bits 7:5 leaves the configuration unchanged.
- R3: `poll_active_o` is 1 in the cycle after a clock edge at which `atn_i` and `eoi_i` are both 1, and 0 otherwise.
- R4: While the disable bit is 1, `dio_drive_o` stays 0.
- R5: During a poll with a response enabled and ist equal to the sense bit, `dio_drive_o` has only bit N set, where N is the configured line number (0 selects DIO1, 7 selects DIO8).
- R6: When ist differs from the sense bit, `dio_drive_o` stays 0. Sense 1 means in phase and sense 0 means reverse phase.
- R7: With the source select at 0, ist equals the host poll flag, which is written through `flag_we_i` and `flag_i`.
- R8: With the source select at 1 (written through `src_we_i` and `src_i`), ist equals `srq_state_i` and the poll flag has no effect.
- R9: One clock after either `atn_i` or `eoi_i` goes to 0, `dio_drive_o` is 0.
- R10: At most one bit of `dio_drive_o` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 8 | Configuration byte (011, disable, sense, line[2:0]) |
| flag_we_i | input | 1 | Poll flag write strobe |
| flag_i | input | 1 | Poll flag value |
| src_we_i | input | 1 | Source select write strobe |
| src_i | input | 1 | Source select: 0 uses the flag, 1 uses the service-request state |
| srq_state_i | input | 1 | Service-request state of the device |
| atn_i | input | 1 | ATN true (active high) |
| eoi_i | input | 1 | EOI true (active high) |
| dio_drive_o | output | 8 | Drive vector; bit k asserts DIO(k+1) |
| poll_active_o | output | 1 | Registered poll-identified flag |

## Verification
The hardest case to reach is R8. There the flag and the service-request state disagree, and the flag must be proven to have no effect. The stimulus reaches it by setting the source select and holding `srq_state_i` at the sense value. The flag is then toggled both ways between polls, and each poll must still show the same line. A second case also needs care. The sense is flipped while the other inputs stay fixed, so that the reverse-phase rule can be told apart from a plain disable.

// File: rtl/ppoll_pkg.sv
package ppoll_pkg;
  localparam int unsigned LINE_CNT = 8;
  localparam int unsigned SEL_W    = $clog2(LINE_CNT);
  localparam logic [2:0]  CFG_TAG  = 3'b011;

  typedef struct packed {
    logic             dis;
    logic             sense;
    logic [SEL_W-1:0] sel;
  } ppoll_cfg_t;
endpackage

// File: rtl/ppoll_cfg_regs.sv
module ppoll_cfg_regs
  import ppoll_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_data_i,
  input  logic       flag_we_i,
  input  logic       flag_i,
  input  logic       src_we_i,
  input  logic       src_i,
  output ppoll_cfg_t cfg_o,
  output logic       flag_o,
  output logic       src_o
);
  logic tag_ok;
  assign tag_ok = (cfg_data_i[7:5] == CFG_TAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '{dis: 1'b1, sense: 1'b0, sel: '0};
      flag_o <= 1'b0;
      src_o  <= 1'b0;
    end else begin
      if (cfg_we_i && tag_ok) begin
        cfg_o.dis   <= cfg_data_i[4];
        cfg_o.sense <= cfg_data_i[3];
        cfg_o.sel   <= cfg_data_i[SEL_W-1:0];
      end
      if (flag_we_i) flag_o <= flag_i;
      if (src_we_i)  src_o  <= src_i;
    end
  end

  assert_cfg_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_data_i[7:5] != 3'b011) |=> $stable(cfg_o));
endmodule

// File: rtl/ppoll_ist_sel.sv
module ppoll_ist_sel (
  input  logic src_i,
  input  logic flag_i,
  input  logic srq_i,
  output logic ist_o
);
  always_comb ist_o = src_i ? srq_i : flag_i;
endmodule

// File: rtl/ppoll_line_drive.sv
module ppoll_line_drive
  import ppoll_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ppoll_cfg_t          cfg_i,
  input  logic                ist_i,
  input  logic                atn_i,
  input  logic                eoi_i,
  output logic [LINE_CNT-1:0] drive_o,
  output logic                active_o
);
  logic                identify;
  logic                respond;
  logic [LINE_CNT-1:0] line_dec;

  assign identify = atn_i && eoi_i;
  assign respond  = identify && !cfg_i.dis && (ist_i == cfg_i.sense);

  for (genvar k = 0; k < LINE_CNT; k++) begin : g_dec
    assign line_dec[k] = (cfg_i.sel == SEL_W'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o  <= '0;
      active_o <= 1'b0;
    end else begin
      drive_o  <= respond ? line_dec : '0;
      active_o <= identify;
    end
  end

  assert_one_line_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(drive_o));
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(atn_i && eoi_i) |=> (drive_o == '0));
  assert_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.dis |=> (drive_o == '0));
  assert_mismatch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ist_i != cfg_i.sense) |=> (drive_o == '0));
  assert_drive_needs_poll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o != '0) |-> active_o);
endmodule

// File: rtl/ppoll_resp.sv
module ppoll_resp
  import ppoll_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_data_i,
  input  logic       flag_we_i,
  input  logic       flag_i,
  input  logic       src_we_i,
  input  logic       src_i,
  input  logic       srq_state_i,
  input  logic       atn_i,
  input  logic       eoi_i,
  output logic [7:0] dio_drive_o,
  output logic       poll_active_o
);
  ppoll_cfg_t cfg;
  logic       flag_q;
  logic       src_q;
  logic       ist;

  ppoll_cfg_regs u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_data_i,
    .flag_we_i, .flag_i, .src_we_i, .src_i,
    .cfg_o(cfg), .flag_o(flag_q), .src_o(src_q)
  );

  ppoll_ist_sel u_ist (
    .src_i(src_q), .flag_i(flag_q), .srq_i(srq_state_i), .ist_o(ist)
  );

  ppoll_line_drive u_drv (
    .clk_i, .rst_ni, .cfg_i(cfg), .ist_i(ist), .atn_i, .eoi_i,
    .drive_o(dio_drive_o), .active_o(poll_active_o)
  );
endmodule

// File: tb/sim_ppoll_resp.sv
module sim_ppoll_resp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0, flag_we = 0, flag_v = 0, src_we = 0, src_v = 0;
  logic [7:0] cfg_d = '0;
  logic       srq = 0, atn = 0, eoi = 0;
  logic [7:0] dio;
  logic       act;
  int         errors = 0, checks = 0;

  always #4 clk = ~clk;

  ppoll_resp u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_data_i(cfg_d),
    .flag_we_i(flag_we), .flag_i(flag_v), .src_we_i(src_we), .src_i(src_v),
    .srq_state_i(srq), .atn_i(atn), .eoi_i(eoi),
    .dio_drive_o(dio), .poll_active_o(act)
  );

  task automatic chk(string req, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got act=%b dio=%b, expected act=%b dio=%b",
               req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic wr_cfg(logic [7:0] b);
    @(negedge clk); cfg_d = b; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic wr_flag(logic v);
    @(negedge clk); flag_v = v; flag_we = 1;
    @(negedge clk); flag_we = 0;
  endtask
  task automatic wr_src(logic v);
    @(negedge clk); src_v = v; src_we = 1;
    @(negedge clk); src_we = 0;
  endtask
  // raise ATN+EOI, sample one cycle later, then end poll
  task automatic poll(string req, logic [7:0] exp);
    @(negedge clk); atn = 1; eoi = 1;
    @(negedge clk); chk(req, {act, dio}, {1'b1, exp});
    atn = 0; eoi = 0;
    @(negedge clk); chk({req, "/R9"}, {act, dio}, 9'h000);
  endtask

  task automatic t_reset;
    chk("R1", {act, dio}, 9'h000);
    poll("R1", 8'h00);
  endtask
  task automatic t_lines;
    wr_flag(1);
    for (int k = 0; k < 8; k++) begin
      wr_cfg({3'b011, 1'b0, 1'b1, 3'(k)});
      poll("R5", 8'(1 << k));
    end
  endtask
  task automatic t_disable;
    wr_cfg(8'b011_1_1_010);
    poll("R4", 8'h00);
  endtask
  task automatic t_bad_tag;
    wr_cfg(8'b011_0_1_101);
    wr_cfg(8'b111_0_1_001);
    poll("R2", 8'b0010_0000);
    wr_cfg(8'b010_1_1_001);
    poll("R2", 8'b0010_0000);
  endtask
  task automatic t_sense;
    wr_cfg(8'b011_0_0_011);
    poll("R6", 8'h00);
    wr_flag(0);
    poll("R7", 8'b0000_1000);
    wr_cfg(8'b011_0_1_011);
    poll("R6", 8'h00);
  endtask
  task automatic t_srq_src;
    wr_src(1);
    srq = 1; wr_flag(0);
    poll("R8", 8'b0000_1000);
    wr_flag(1);
    poll("R8", 8'b0000_1000);
    srq = 0;
    poll("R8", 8'h00);
    wr_src(0);
    poll("R7", 8'b0000_1000);
  endtask
  task automatic t_partial;
    @(negedge clk); atn = 1; eoi = 0;
    @(negedge clk); chk("R3", {act, dio}, 9'h000);
    atn = 0; eoi = 1;
    @(negedge clk); chk("R3", {act, dio}, 9'h000);
    atn = 1;
    @(negedge clk); chk("R5", {act, dio}, {1'b1, 8'b0000_1000});
    eoi = 0;
    @(negedge clk); chk("R9", {act, dio}, 9'h000);
    atn = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset; t_lines; t_disable; t_bad_tag; t_sense; t_srq_src; t_partial;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule